// File: doc/BRIEF.md
# Dual Sound-Generator Register Write Sequencer

This block sits between a host and two identical three-channel programmable sound generators whose register access is controlled by a three-bit bus-control field (a chip-reset bit, a direction bit and a bus-control bit) plus an 8-bit multiplexed address/data port. A host asks for a register write by giving a register index and a value. The block then plays the five-phase control handshake those chips expect: first the address is latched, then the data is written. It drives both chip buses in lockstep, so the two chips always see the same phase, address and value in the same cycle.

The block also runs two more commands. A chip-reset command pulses the control field low and then releases it. A bulk-clear command writes zero to every register of both chips, from the highest index down to index zero. Every phase is held for a host-chosen number of clock cycles so that the chips' setup and hold times can be met at any clock rate. The host side uses a simple handshake. The host raises `req_valid` while the block is idle. `busy` stays high for the whole sequence, and a one-cycle `done` pulse marks its end.

Top module: `psg_bus_seq`

## Requirements
- R1: While `rst_n` is low, `bus_oe` is 0, both control fields read 3'b100 (inactive), both data ports read 0, and `busy` and `done` are 0. From the first clock edge after release, `bus_oe` is 1 and the buses keep idling at 3'b100 with data 0.
- R2: A write command (`req_op`=0) produces these control codes, each held for H cycles, from the clock edge that accepts it: 3'b100, 3'b111 (latch address), 3'b100, 3'b110 (write data), 3'b100. The code 3'b101 (read) never appears.
- R3: During the first three phases of a write, the data port carries the register index, zero-extended to 8 bits. During the last two phases it carries the value. While idle it carries 0.
- R4: Bus 0 and bus 1 carry identical control codes and data in every cycle.
- R5: A chip-reset command (`req_op`=1) drives the control field to 3'b000 for H cycles, then to 3'b100 for H cycles, with data 0 throughout.
- R6: A clear command (`req_op`=2) issues 15 back-to-back write sequences with value 0 to register indices 14, 13, … 0 in that order. It produces a single `done` pulse, after the last one.
- R7: H equals `hold_cycles` sampled at acceptance; a value of 0 is treated as 1. Changes to `hold_cycles` after acceptance have no effect on the running sequence.
- R8: `busy` is 1 from the accepting edge until the final phase ends. On the next cycle `busy` is 0 and `done` is 1 for exactly one cycle. A request made while `busy` is 1 is ignored.
- R9: A request with `req_op`=3 is ignored: `busy` stays 0 and the buses stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_op | input | 2 | 0 write, 1 chip reset, 2 clear all, 3 ignored |
| req_reg | input | 4 | Register index for a write |
| req_data | input | 8 | Value for a write |
| hold_cycles | input | 4 | Cycles per phase (0 acts as 1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse at command completion |
| bus_oe | output | 1 | Output enable for all control and data lines |
| bus0_ctl | output | 3 | Chip 0 control field {reset, dir, bc} |
| bus0_data | output | 8 | Chip 0 address/data port |
| bus1_ctl | output | 3 | Chip 1 control field {reset, dir, bc} |
| bus1_data | output | 8 | Chip 1 address/data port |

## Verification
The assertions assume that the host only encodes commands 0 to 3 and keeps `req_valid` glitch-free relative to the clock. They also assume that requests made while busy are really meant to be dropped, so the busy-to-accept property only looks at idle cycles. The stimulus changes every input on the falling edge and holds it across the next rising edge. Requests made while busy, and changes to `hold_cycles` in the middle of a sequence, are applied on purpose to show that they have no effect. The clear test runs with a short hold so that all fifteen writes can be compared cycle by cycle.

// File: rtl/psg_seq_pkg.sv
package psg_seq_pkg;
  // control field bits: {chip reset, direction, bus control}
  localparam logic [2:0] CTL_RESET    = 3'b000;
  localparam logic [2:0] CTL_INACTIVE = 3'b100;
  localparam logic [2:0] CTL_READ     = 3'b101;
  localparam logic [2:0] CTL_WRITE    = 3'b110;
  localparam logic [2:0] CTL_LATCH    = 3'b111;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_RESET = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_LATCH   = 3'd2,
    PH_GAP     = 3'd3,
    PH_WRITE   = 3'd4,
    PH_TAIL    = 3'd5,
    PH_RST_LOW = 3'd6,
    PH_RST_REL = 3'd7
  } phase_e;
endpackage

// File: rtl/psg_hold_timer.sv
module psg_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HOLD_W-1:0] hold,
  output logic              expire
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == hold - 1'b1);

  always_comb begin
    if (!run || expire) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/psg_seq_ctrl.sv
module psg_seq_ctrl
  import psg_seq_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int DATA_W   = 8,
  parameter int HOLD_W   = 4,
  parameter int NUM_REGS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_data,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              expire,
  output phase_e            phase,
  output logic [REG_W-1:0]  addr,
  output logic [DATA_W-1:0] value,
  output logic [HOLD_W-1:0] hold,
  output logic              busy,
  output logic              done
);
  localparam logic [REG_W-1:0] TOP_REG = REG_W'(NUM_REGS - 1);

  phase_e            ph_q, ph_d;
  op_e               op_q, op_d;
  logic [REG_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              done_q, done_d;
  logic              accept;

  assign busy   = (ph_q != PH_IDLE);
  assign accept = !busy && req_valid && (op_e'(req_op) != OP_NONE);

  always_comb begin
    ph_d   = ph_q;
    op_d   = op_q;
    addr_d = addr_q;
    val_d  = val_q;
    hold_d = hold_q;
    done_d = 1'b0;
    if (accept) begin
      op_d   = op_e'(req_op);
      hold_d = (hold_cycles == '0) ? HOLD_W'(1) : hold_cycles;
      addr_d = (op_e'(req_op) == OP_CLEAR) ? TOP_REG : req_reg;
      val_d  = (op_e'(req_op) == OP_WRITE) ? req_data : '0;
      ph_d   = (op_e'(req_op) == OP_RESET) ? PH_RST_LOW : PH_SETUP;
    end else if (expire) begin
      unique case (ph_q)
        PH_SETUP:   ph_d = PH_LATCH;
        PH_LATCH:   ph_d = PH_GAP;
        PH_GAP:     ph_d = PH_WRITE;
        PH_WRITE:   ph_d = PH_TAIL;
        PH_TAIL: begin
          if (op_q == OP_CLEAR && addr_q != '0) begin
            addr_d = addr_q - 1'b1;
            ph_d   = PH_SETUP;
          end else begin
            ph_d   = PH_IDLE;
            done_d = 1'b1;
          end
        end
        PH_RST_LOW: ph_d = PH_RST_REL;
        PH_RST_REL: begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
        default:    ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_WRITE;
      addr_q <= '0;
      val_q  <= '0;
      hold_q <= HOLD_W'(1);
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      val_q  <= val_d;
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end

  assign phase = ph_q;
  assign addr  = addr_q;
  assign value = val_q;
  assign hold  = hold_q;
  assign done  = done_q;
endmodule

// File: rtl/psg_bus_drive.sv
module psg_bus_drive
  import psg_seq_pkg::*;
#(
  parameter int N_CHIP = 2,
  parameter int REG_W  = 4,
  parameter int DATA_W = 8
) (
  input  phase_e                        phase,
  input  logic [REG_W-1:0]              addr,
  input  logic [DATA_W-1:0]             value,
  output logic [N_CHIP-1:0][2:0]        ctl_o,
  output logic [N_CHIP-1:0][DATA_W-1:0] data_o
);
  logic [2:0]        ctl_c;
  logic [DATA_W-1:0] data_c;

  always_comb begin
    unique case (phase)
      PH_LATCH:   ctl_c = CTL_LATCH;
      PH_WRITE:   ctl_c = CTL_WRITE;
      PH_RST_LOW: ctl_c = CTL_RESET;
      default:    ctl_c = CTL_INACTIVE;
    endcase
    unique case (phase)
      PH_SETUP, PH_LATCH, PH_GAP: data_c = DATA_W'(addr);
      PH_WRITE, PH_TAIL:          data_c = value;
      default:                    data_c = '0;
    endcase
  end

  for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
    assign ctl_o[c]  = ctl_c;
    assign data_o[c] = data_c;
  end
endmodule

// File: rtl/psg_bus_seq.sv
module psg_bus_seq
  import psg_seq_pkg::*;
#(
  parameter int REG_W    = 4,
  parameter int DATA_W   = 8,
  parameter int HOLD_W   = 4,
  parameter int NUM_REGS = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_data,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              busy,
  output logic              done,
  output logic              bus_oe,
  output logic [2:0]        bus0_ctl,
  output logic [DATA_W-1:0] bus0_data,
  output logic [2:0]        bus1_ctl,
  output logic [DATA_W-1:0] bus1_data
);
  localparam int N_CHIP = 2;

  phase_e                        phase;
  logic [REG_W-1:0]              addr;
  logic [DATA_W-1:0]             value;
  logic [HOLD_W-1:0]             hold;
  logic                          expire;
  logic [N_CHIP-1:0][2:0]        ctl_w;
  logic [N_CHIP-1:0][DATA_W-1:0] data_w;
  logic                          oe_q;

  psg_seq_ctrl #(
    .REG_W(REG_W), .DATA_W(DATA_W), .HOLD_W(HOLD_W), .NUM_REGS(NUM_REGS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_data(req_data), .hold_cycles(hold_cycles),
    .expire(expire), .phase(phase), .addr(addr), .value(value),
    .hold(hold), .busy(busy), .done(done)
  );

  psg_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .hold(hold), .expire(expire)
  );

  psg_bus_drive #(.N_CHIP(N_CHIP), .REG_W(REG_W), .DATA_W(DATA_W)) u_drive (
    .phase(phase), .addr(addr), .value(value), .ctl_o(ctl_w), .data_o(data_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= 1'b1;
  end

  assign bus_oe    = oe_q;
  assign bus0_ctl  = ctl_w[0];
  assign bus0_data = data_w[0];
  assign bus1_ctl  = ctl_w[1];
  assign bus1_data = data_w[1];
endmodule

// File: rtl/psg_bus_seq_chk.sv
module psg_bus_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              busy,
  input logic              done,
  input logic [2:0]        bus0_ctl,
  input logic [DATA_W-1:0] bus0_data,
  input logic [2:0]        bus1_ctl,
  input logic [DATA_W-1:0] bus1_data
);
  p_lockstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_ctl == bus1_ctl) && (bus0_data == bus1_data));

  p_no_read_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus0_ctl != 3'b101);

  p_latch_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_ctl == 3'b111 && $past(bus0_ctl) != 3'b111) |-> $past(bus0_ctl) == 3'b100);

  p_write_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_ctl == 3'b110 && $past(bus0_ctl) != 3'b110) |-> $past(bus0_ctl) == 3'b100);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus0_ctl == 3'b100 && bus0_data == '0));

  p_reset_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus0_ctl == 3'b000) |-> busy);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op != 2'd3) |=> busy);

  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 2'd3) |=> !busy);
endmodule

bind psg_bus_seq psg_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .busy(busy), .done(done), .bus0_ctl(bus0_ctl), .bus0_data(bus0_data),
  .bus1_ctl(bus1_ctl), .bus1_data(bus1_data)
);

// File: tb/tb_psg_bus_seq.sv
`timescale 1ns/1ps
module tb_psg_bus_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_op;
  logic [3:0] req_reg;
  logic [7:0] req_data;
  logic [3:0] hold_cycles;
  logic       busy, done, bus_oe;
  logic [2:0] bus0_ctl, bus1_ctl;
  logic [7:0] bus0_data, bus1_data;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  psg_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_data(req_data), .hold_cycles(hold_cycles),
    .busy(busy), .done(done), .bus_oe(bus_oe),
    .bus0_ctl(bus0_ctl), .bus0_data(bus0_data),
    .bus1_ctl(bus1_ctl), .bus1_data(bus1_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " ctl0"}, {29'd0, bus0_ctl}, 32'h4);
    chk({req, " ctl1"}, {29'd0, bus1_ctl}, 32'h4);
    chk({req, " data0"}, {24'd0, bus0_data}, 32'h0);
    chk({req, " busy"}, {31'd0, busy}, 32'h0);
  endtask

  // issue a request on one falling edge, drop it on the next
  task automatic issue(input logic [1:0] op, input logic [3:0] r, input logic [7:0] v,
                       input logic [3:0] h);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_reg = r; req_data = v; hold_cycles = h;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // one expected write: index k counts cycles from acceptance
  task automatic chk_write_cycle(input int k, input int h, input logic [3:0] r,
                                 input logic [7:0] v, input string tag);
    int ph = k / h;
    logic [2:0] ec;
    logic [7:0] ed;
    case (ph)
      0: begin ec = 3'b100; ed = {4'd0, r}; end
      1: begin ec = 3'b111; ed = {4'd0, r}; end
      2: begin ec = 3'b100; ed = {4'd0, r}; end
      3: begin ec = 3'b110; ed = v; end
      default: begin ec = 3'b100; ed = v; end
    endcase
    chk({tag, " R2 ctl"}, {29'd0, bus0_ctl}, {29'd0, ec});
    chk({tag, " R3 data"}, {24'd0, bus0_data}, {24'd0, ed});
    chk({tag, " R4 ctl match"}, {29'd0, bus1_ctl}, {29'd0, bus0_ctl});
    chk({tag, " R4 data match"}, {24'd0, bus1_data}, {24'd0, bus0_data});
    chk({tag, " R8 busy"}, {31'd0, busy}, 32'h1);
    chk({tag, " R6/R8 no early done"}, {31'd0, done}, 32'h0);
  endtask

  task automatic chk_end(input string tag);
    chk({tag, " R8 done pulse"}, {31'd0, done}, 32'h1);
    chk_idle({tag, " R8 end idle"});
    @(negedge clk);
    chk({tag, " R8 done cleared"}, {31'd0, done}, 32'h0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_reg = 4'd0;
    req_data = 8'd0; hold_cycles = 4'd1;
    #12;
    chk("R1 oe in reset", {31'd0, bus_oe}, 32'h0);
    chk("R1 done in reset", {31'd0, done}, 32'h0);
    chk_idle("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", {31'd0, bus_oe}, 32'h1);
    chk_idle("R1 after reset");
  endtask

  // poke: 1 sends a competing request mid-run, 2 changes hold mid-run
  task automatic t_write(input logic [3:0] r, input logic [7:0] v, input logic [3:0] h,
                         input int poke, input string tag);
    int he = (h == 0) ? 1 : int'(h);
    issue(2'd0, r, v, h);
    for (int k = 0; k < 5 * he; k++) begin
      chk_write_cycle(k, he, r, v, tag);
      if (k == 1 && poke == 1) begin
        req_valid = 1'b1; req_op = 2'd0; req_reg = ~r; req_data = ~v;
      end
      if (k == 1 && poke == 2) hold_cycles = 4'd9;
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk_end(tag);
  endtask

  task automatic t_chip_reset(input logic [3:0] h);
    issue(2'd1, 4'd5, 8'hA5, h);
    for (int k = 0; k < 2 * int'(h); k++) begin
      chk("R5 reset ctl", {29'd0, bus0_ctl}, (k < int'(h)) ? 32'h0 : 32'h4);
      chk("R5 reset data", {24'd0, bus0_data}, 32'h0);
      chk("R4 reset ctl match", {29'd0, bus1_ctl}, {29'd0, bus0_ctl});
      @(negedge clk);
    end
    chk_end("R5 reset");
  endtask

  task automatic t_clear(input logic [3:0] h);
    int he = int'(h);
    issue(2'd2, 4'd3, 8'h77, h);
    for (int w = 0; w < 15; w++) begin
      for (int k = 0; k < 5 * he; k++) begin
        chk_write_cycle(k, he, 4'(14 - w), 8'h00, "R6 clear");
        @(negedge clk);
      end
    end
    chk_end("R6 clear");
  endtask

  task automatic t_bad_op();
    issue(2'd3, 4'd2, 8'h11, 4'd1);
    chk_idle("R9 op3 ignored");
    @(negedge clk);
    chk_idle("R9 op3 still idle");
  endtask

  initial begin
    #1_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_write(4'd4, 8'h51, 4'd1, 0, "R2 write h1");
    t_write(4'd10, 8'h0C, 4'd3, 0, "R3 write h3");
    t_write(4'd7, 8'h38, 4'd0, 0, "R7 hold zero");
    t_write(4'd13, 8'hC3, 4'd2, 2, "R7 hold change");
    t_write(4'd2, 8'h5A, 4'd2, 1, "R8 busy ignore");
    @(negedge clk);
    chk_idle("R8 ignored request left no work");
    t_chip_reset(4'd3);
    t_clear(4'd1);
    t_bad_op();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule